// File: doc/BRIEF.md
# Dual-Channel Interrupt Cause Controller

This block gathers event pulses from two DMA channels into one shared 32-bit cause register. Each channel owns a 16-bit half: channel 0 holds bits [15:0] and channel 1 holds bits [31:16]. A matching mask register decides which cause bits may raise that channel's interrupt line. Once an event bit is captured it stays set until software clears it.

Software clears cause bits by writing zeros. Writing a one leaves a bit as it was. Because of this, the handler for one channel can write all ones over the other channel's half and leave it untouched. The mask register is an ordinary read/write register, so software updates it by read-modify-write. Next to the interrupt line, each channel drives an error-summary output. This output covers the real fault causes and leaves out the one benign condition.

Both registers can always be read on dedicated outputs. Writes go through a single write port that has a one-bit register select.

Top module: `icc_top`

## Requirements
- R1: After reset the cause and mask registers both read zero, and every interrupt and error output is low.
- R2: A 1 on evtIn bit k sets cause bit k on the next clock edge. A set cause bit stays set in every cycle that brings neither a cause write nor a new event.
- R3: A cause write (wrEn=1, wrSel=0) clears every cause bit where wrData holds 0 and leaves every bit where wrData holds 1 unchanged. Writing 0x0000FFFF therefore clears only channel 1 (bits [31:16]).
- R4: If an event bit arrives in the same cycle as a cause write that clears that bit, the bit is set after the edge.
- R5: A mask write (wrEn=1, wrSel=1) loads wrData into the mask register, and the new value appears on maskOut after the edge.
- R6: irqOut[c] is high exactly when some bit i of field c (register bit 16*c+i) is set in both the cause and mask registers.
- R7: errOut[c] is high exactly when any of bits 5 to 9 of field c is set in the cause register. Bit 4 (the benign condition) and bit 0 (end of chain) never raise it.
- R8: A cause write never changes the mask register. A mask write never clears a cause bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| evtIn | input | 32 | One-cycle event pulses, packed per channel |
| wrEn | input | 1 | Write strobe |
| wrSel | input | 1 | Write target: 0 cause, 1 mask |
| wrData | input | 32 | Write data |
| causeOut | output | 32 | Current cause register |
| maskOut | output | 32 | Current mask register |
| irqOut | output | 2 | Per-channel interrupt, one bit per channel |
| errOut | output | 2 | Per-channel error summary |

## Verification
The bench sends an event and a clearing write into the same cycle. A design that let the clear win would lose that event, and the stored bit would read back as zero. It clears one channel by writing ones over the other half. A design that treated written ones as sets or toggles would corrupt the neighbour's pending bits. It raises bit 4 and bit 0 on their own, which catches an error summary whose bit range is one off. It also masks an individual cause bit, which catches an interrupt that ignores the mask or reads the wrong half of the register.

// File: rtl/icc_pkg.sv
package icc_pkg;

  typedef enum logic {
    SEL_CAUSE = 1'b0,
    SEL_MASK  = 1'b1
  } regSel_e;

  typedef struct packed {
    logic causeWr;
    logic maskWr;
  } iccStrobe_t;

endpackage

// File: rtl/icc_ctrl.sv
module icc_ctrl
  import icc_pkg::*;
(
  input  logic       wrEn,
  input  logic       wrSel,
  output iccStrobe_t strobe
);

  always_comb begin
    strobe         = '0;
    strobe.causeWr = wrEn && (regSel_e'(wrSel) == SEL_CAUSE);
    strobe.maskWr  = wrEn && (regSel_e'(wrSel) == SEL_MASK);
  end

endmodule

// File: rtl/icc_datapath.sv
module icc_datapath
  import icc_pkg::*;
#(
  parameter int NUM_CH  = 2,
  parameter int FIELD_W = 16,
  parameter int ERR_LO  = 5,
  parameter int ERR_HI  = 9,
  localparam int REG_W  = NUM_CH * FIELD_W,
  localparam int ERR_W  = ERR_HI - ERR_LO + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  iccStrobe_t        strobe,
  input  logic [REG_W-1:0]  evtIn,
  input  logic [REG_W-1:0]  wrData,
  output logic [REG_W-1:0]  causeQ,
  output logic [REG_W-1:0]  maskQ,
  output logic [NUM_CH-1:0] irqOut,
  output logic [NUM_CH-1:0] errOut
);

  logic [REG_W-1:0] keepBits;
  logic [REG_W-1:0] causeNext;

  // zero in a written cause bit clears it; new events override the clear
  always_comb begin
    keepBits  = strobe.causeWr ? wrData : '1;
    causeNext = (causeQ & keepBits) | evtIn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      causeQ <= '0;
      maskQ  <= '0;
    end else begin
      causeQ <= causeNext;
      if (strobe.maskWr) maskQ <= wrData;
    end
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    logic [FIELD_W-1:0] chCause;
    logic [FIELD_W-1:0] chMask;
    logic [ERR_W-1:0]   chErr;
    assign chCause   = causeQ[c*FIELD_W +: FIELD_W];
    assign chMask    = maskQ[c*FIELD_W +: FIELD_W];
    assign chErr     = chCause[ERR_LO +: ERR_W];
    assign irqOut[c] = |(chCause & chMask);
    assign errOut[c] = |chErr;
  end

endmodule

// File: rtl/icc_top.sv
module icc_top
  import icc_pkg::*;
#(
  parameter int NUM_CH  = 2,
  parameter int FIELD_W = 16,
  parameter int ERR_LO  = 5,
  parameter int ERR_HI  = 9,
  localparam int REG_W  = NUM_CH * FIELD_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [REG_W-1:0]  evtIn,
  input  logic              wrEn,
  input  logic              wrSel,
  input  logic [REG_W-1:0]  wrData,
  output logic [REG_W-1:0]  causeOut,
  output logic [REG_W-1:0]  maskOut,
  output logic [NUM_CH-1:0] irqOut,
  output logic [NUM_CH-1:0] errOut
);

  iccStrobe_t strobe;

  icc_ctrl u_ctrl (
    .wrEn   (wrEn),
    .wrSel  (wrSel),
    .strobe (strobe)
  );

  icc_datapath #(
    .NUM_CH  (NUM_CH),
    .FIELD_W (FIELD_W),
    .ERR_LO  (ERR_LO),
    .ERR_HI  (ERR_HI)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .evtIn  (evtIn),
    .wrData (wrData),
    .causeQ (causeOut),
    .maskQ  (maskOut),
    .irqOut (irqOut),
    .errOut (errOut)
  );

endmodule

// File: rtl/icc_checker.sv
module icc_checker #(
  parameter int NUM_CH  = 2,
  parameter int FIELD_W = 16,
  parameter int ERR_LO  = 5,
  parameter int ERR_HI  = 9,
  localparam int REG_W  = NUM_CH * FIELD_W,
  localparam int ERR_W  = ERR_HI - ERR_LO + 1
) (
  input logic              clk,
  input logic              rstN,
  input logic [REG_W-1:0]  evtIn,
  input logic              wrEn,
  input logic              wrSel,
  input logic [REG_W-1:0]  wrData,
  input logic [REG_W-1:0]  causeOut,
  input logic [REG_W-1:0]  maskOut,
  input logic [NUM_CH-1:0] irqOut,
  input logic [NUM_CH-1:0] errOut
);

  logic isCauseWr;
  logic isMaskWr;
  assign isCauseWr = wrEn && !wrSel;
  assign isMaskWr  = wrEn && wrSel;

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!isCauseWr && evtIn == '0) |=> (causeOut == $past(causeOut)));

  assert_clear_R3: assert property (@(posedge clk) disable iff (!rstN)
    (isCauseWr && evtIn == '0) |=> (causeOut == ($past(causeOut) & $past(wrData))));

  assert_event_wins_R4: assert property (@(posedge clk) disable iff (!rstN)
    (evtIn != '0) |=> ((causeOut & $past(evtIn)) == $past(evtIn)));

  assert_mask_load_R5: assert property (@(posedge clk) disable iff (!rstN)
    isMaskWr |=> (maskOut == $past(wrData)));

  assert_mask_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    !isMaskWr |=> $stable(maskOut));

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    assert_irq_R6: assert property (@(posedge clk) disable iff (!rstN)
      irqOut[c] == |(causeOut[c*FIELD_W +: FIELD_W] & maskOut[c*FIELD_W +: FIELD_W]));
    assert_err_R7: assert property (@(posedge clk) disable iff (!rstN)
      errOut[c] == |causeOut[c*FIELD_W + ERR_LO +: ERR_W]);
  end

endmodule

bind icc_top icc_checker #(
  .NUM_CH  (NUM_CH),
  .FIELD_W (FIELD_W),
  .ERR_LO  (ERR_LO),
  .ERR_HI  (ERR_HI)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .evtIn    (evtIn),
  .wrEn     (wrEn),
  .wrSel    (wrSel),
  .wrData   (wrData),
  .causeOut (causeOut),
  .maskOut  (maskOut),
  .irqOut   (irqOut),
  .errOut   (errOut)
);

// File: tb/tb_icc_top.sv
`timescale 1ns/1ps
module tb_icc_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] evtIn = '0;
  logic        wrEn = 1'b0;
  logic        wrSel = 1'b0;
  logic [31:0] wrData = '0;
  logic [31:0] causeOut, maskOut;
  logic [1:0]  irqOut, errOut;

  always #2 clk = ~clk;

  icc_top dut (
    .clk(clk), .rstN(rstN), .evtIn(evtIn), .wrEn(wrEn), .wrSel(wrSel),
    .wrData(wrData), .causeOut(causeOut), .maskOut(maskOut),
    .irqOut(irqOut), .errOut(errOut)
  );

  int testsRun = 0;
  int testsFailed = 0;
  bit done = 0;

  logic [31:0] modelCause = '0;
  logic [31:0] modelMask = '0;

  logic [31:0] qCause[$];
  logic [31:0] qMask[$];
  logic [1:0]  qIrq[$];
  logic [1:0]  qErr[$];
  string       qTag[$];

  function automatic logic [1:0] calcIrq(logic [31:0] c, logic [31:0] m);
    return {|(c[31:16] & m[31:16]), |(c[15:0] & m[15:0])};
  endfunction

  function automatic logic [1:0] calcErr(logic [31:0] c);
    return {|c[25:21], |c[9:5]};
  endfunction

  task automatic pushExpect(string tag);
    qCause.push_back(modelCause);
    qMask.push_back(modelMask);
    qIrq.push_back(calcIrq(modelCause, modelMask));
    qErr.push_back(calcErr(modelCause));
    qTag.push_back(tag);
  endtask

  // driver: one clock of stimulus, then the expected register state
  task automatic step(logic [31:0] evt, logic we, logic sel, logic [31:0] d, string tag);
    @(negedge clk);
    evtIn = evt; wrEn = we; wrSel = sel; wrData = d;
    @(posedge clk);
    #1;
    if (we && !sel) modelCause = modelCause & d;
    modelCause = modelCause | evt;
    if (we && sel) modelMask = d;
    pushExpect(tag);
    evtIn = '0; wrEn = 1'b0; wrSel = 1'b0; wrData = '0;
  endtask

  // monitor: compare at the falling edge after each update
  initial begin
    forever begin
      @(negedge clk);
      if (qTag.size() > 0) begin
        logic [31:0] eC, eM;
        logic [1:0]  eI, eE;
        string t;
        eC = qCause.pop_front(); eM = qMask.pop_front();
        eI = qIrq.pop_front();   eE = qErr.pop_front();
        t  = qTag.pop_front();
        testsRun++;
        if (causeOut !== eC || maskOut !== eM || irqOut !== eI || errOut !== eE) begin
          testsFailed++;
          $display("FAIL %s: actual cause=%h mask=%h irq=%b err=%b expected cause=%h mask=%h irq=%b err=%b",
                   t, causeOut, maskOut, irqOut, errOut, eC, eM, eI, eE);
        end
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      testsFailed++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    pushExpect("R1 reset state");
    step(32'h0, 1'b1, 1'b1, 32'h0001_0001, "R5 mask load");
    step(32'h0000_0001, 1'b0, 1'b0, 32'h0, "R2 R6 ch0 end-of-chain event");
    step(32'h0, 1'b0, 1'b0, 32'h0, "R2 bit stays set");
    step(32'h0, 1'b1, 1'b0, 32'hFFFF_FFFE, "R3 clear bit0 by zero");
    step(32'h0000_0010, 1'b0, 1'b0, 32'h0, "R7 benign bit4 no error");
    step(32'h0020_0000, 1'b0, 1'b0, 32'h0, "R7 ch1 bit5 error");
    step(32'h0, 1'b1, 1'b0, 32'h0000_FFFF, "R3 clear ch1 only");
    step(32'h0000_0200, 1'b1, 1'b0, 32'h0, "R4 event beats clear");
    step(32'h0, 1'b1, 1'b1, 32'hFFFF_0200, "R8 R6 mask write keeps cause");
    step(32'h0001_0000, 1'b0, 1'b0, 32'h0, "R6 both irqs");
    step(32'h0, 1'b1, 1'b0, 32'h0, "R8 clear all keeps mask");
    step(32'h0010_0000, 1'b0, 1'b0, 32'h0, "R7 ch1 bit4 no error");
    step(32'h0000_0002, 1'b0, 1'b0, 32'h0, "R6 masked ch0 bit1 no irq");
    step(32'h0200_0000, 1'b0, 1'b0, 32'h0, "R7 ch1 bit9 error");
    step(32'h0, 1'b1, 1'b0, 32'hFFFF_FFFF, "R3 all ones write no change");
    repeat (3) @(posedge clk);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule